// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds committed-path stores between address translation and data memory. Stores are allocated in program order with a word address, and each one receives a slot tag. The store data arrives later through a separate write port that uses that tag. At first a store sits in the *finished* region. A retire pulse promotes the oldest finished store to the *completed* region, provided its data has arrived. Completed stores drain to data memory one at a time, oldest first, over a valid/ready write port.

Each cycle a load can present a word address to the lookup port, and the block answers at once (combinationally) with one of three codes:
- **miss**: no buffered store matches, so the load goes on to the cache.
- **stall**: a finished store matches.
- **forward**: only completed stores match, and the data of the youngest one is returned.

A load never takes data from a finished store. Once loads are dispatched out of order, a finished store may be younger than the load. A flush discards every finished store and keeps the completed ones, which still drain to memory.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `mem_valid` is 0 and a valid lookup returns miss (code 0).
- R2: A store is accepted when `alloc_valid` and `alloc_ready` are both high, and it takes the slot reported on `alloc_tag`. Slots are handed out in circular order. `alloc_ready` is 0 while DEPTH stores are held and in any cycle where `flush` is high.
- R3: A store in the finished region is never presented on the memory port. `mem_valid` is high only while at least one completed store is held.
- R4: Completed stores are written to memory oldest first. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold.
- R5: A `retire` pulse moves the oldest finished store to the completed region only if its data was written in an earlier cycle. Otherwise, or when no finished store exists, the pulse is ignored.
- R6: A valid lookup whose address equals no held store returns miss (code 0).
- R7: A valid lookup whose address equals any finished store returns stall (code 1), whether or not that store's data has arrived.
- R8: A valid lookup that equals only completed stores returns forward (code 2). `ld_data` is then the data of the youngest matching completed store.
- R9: In a cycle with `flush` high, all finished stores are removed and `retire` and allocation are ignored. Completed stores are kept and still drain.
- R10: A data write whose tag names a slot that is empty or holds a completed store has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New store request |
| alloc_addr | input | AW | Word address of the new store |
| alloc_ready | output | 1 | Buffer can accept a store |
| alloc_tag | output | PW | Slot given to the store accepted this cycle |
| wr_valid | input | 1 | Store data write |
| wr_tag | input | PW | Slot the data belongs to |
| wr_data | input | DW | Store data |
| retire | input | 1 | Promote oldest finished store |
| flush | input | 1 | Discard all finished stores |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_result | output | 2 | 0 miss, 1 stall, 2 forward |
| ld_data | output | DW | Forwarded data |

## Verification
A wrong pointer or region boundary shows up at the lookup port in the same cycle. It appears as a stall where a forward was due, or as forwarded data from an older store or from a finished one. It also appears at the memory port as a write that arrives too early, out of order or with the wrong data. A lost or duplicated entry changes the occupancy, so `alloc_ready` falls at the wrong count and the tags drift. That is visible within one allocation. The bench keeps a program-order model of the queue and compares every output in every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        LD_MISS  = 2'd0,
        LD_STALL = 2'd1,
        LD_FWD   = 2'd2
    } ld_res_e;

    function automatic ld_res_e classify(input logic stall, input logic hit);
        if (stall)    return LD_STALL;
        else if (hit) return LD_FWD;
        else          return LD_MISS;
    endfunction

endpackage

// File: rtl/sb_ptrs.sv
module sb_ptrs #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  logic          retire_req,
    input  logic          ret_data_ok,
    input  logic          drain_ack,
    input  logic          flush,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [PW-1:0] ret_idx,
    output logic [CW-1:0] cmp_cnt,
    output logic [CW-1:0] fin_cnt,
    output logic          can_alloc,
    output logic          alloc_fire,
    output logic          retire_fire,
    output logic          drain_fire,
    output logic          any_cmp
);
    logic [CW-1:0] total;

    assign total       = cmp_cnt + fin_cnt;
    assign ret_idx     = head + PW'(cmp_cnt);
    assign tail        = head + PW'(total);
    assign can_alloc   = !flush && (total != CW'(DEPTH));
    assign alloc_fire  = alloc_req && can_alloc;
    assign any_cmp     = (cmp_cnt != '0);
    assign drain_fire  = any_cmp && drain_ack;
    assign retire_fire = retire_req && !flush && (fin_cnt != '0) && ret_data_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            cmp_cnt <= '0;
            fin_cnt <= '0;
        end else begin
            if (drain_fire) head <= head + PW'(1);
            cmp_cnt <= cmp_cnt + CW'(retire_fire) - CW'(drain_fire);
            if (flush) fin_cnt <= '0;
            else       fin_cnt <= fin_cnt + CW'(alloc_fire) - CW'(retire_fire);
        end
    end
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         ent_v,
    input  logic [DEPTH-1:0]         ent_c,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [PW-1:0]            head,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    output logic [1:0]               ld_result,
    output logic [DW-1:0]            ld_data
);
    logic          stall, hit;
    logic [PW-1:0] sel, idx;

    // Walk from oldest to youngest; the last completed match wins.
    always_comb begin
        stall = 1'b0;
        hit   = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (ent_v[idx] && ent_addr[idx] == ld_addr) begin
                if (!ent_c[idx]) stall = 1'b1;
                else begin
                    hit = 1'b1;
                    sel = idx;
                end
            end
        end
    end

    assign ld_result = ld_valid ? classify(stall, hit) : LD_MISS;
    assign ld_data   = ent_data[sel];
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_valid,
    input  logic [AW-1:0] alloc_addr,
    output logic          alloc_ready,
    output logic [PW-1:0] alloc_tag,
    input  logic          wr_valid,
    input  logic [PW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data,
    input  logic          retire,
    input  logic          flush,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic [1:0]    ld_result,
    output logic [DW-1:0] ld_data
);
    typedef struct packed {
        logic          v;
        logic          c;
        logic          dv;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } entry_t;

    logic [PW-1:0] head, tail, ret_idx;
    logic [CW-1:0] cmp_cnt, fin_cnt;
    logic          alloc_fire, retire_fire, drain_fire, any_cmp;

    logic [DEPTH-1:0]         valid_vec, cmp_vec, dv_vec;
    logic [DEPTH-1:0][AW-1:0] addr_vec;
    logic [DEPTH-1:0][DW-1:0] data_vec;

    sb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .rst         (rst),
        .alloc_req   (alloc_valid),
        .retire_req  (retire),
        .ret_data_ok (dv_vec[ret_idx]),
        .drain_ack   (mem_ready),
        .flush       (flush),
        .head        (head),
        .tail        (tail),
        .ret_idx     (ret_idx),
        .cmp_cnt     (cmp_cnt),
        .fin_cnt     (fin_cnt),
        .can_alloc   (alloc_ready),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .drain_fire  (drain_fire),
        .any_cmp     (any_cmp)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        entry_t e;
        always_ff @(posedge clk) begin
            if (rst) begin
                e <= '0;
            end else begin
                if (alloc_fire && tail == PW'(i)) begin
                    e.v    <= 1'b1;
                    e.c    <= 1'b0;
                    e.dv   <= 1'b0;
                    e.addr <= alloc_addr;
                end else if (flush && e.v && !e.c) begin
                    e.v <= 1'b0;
                end
                if (drain_fire && head == PW'(i)) begin
                    e.v <= 1'b0;
                    e.c <= 1'b0;
                end
                if (retire_fire && ret_idx == PW'(i)) e.c <= 1'b1;
                if (wr_valid && wr_tag == PW'(i) && e.v && !e.c) begin
                    e.dv   <= 1'b1;
                    e.data <= wr_data;
                end
            end
        end
        assign valid_vec[i] = e.v;
        assign cmp_vec[i]   = e.c;
        assign dv_vec[i]    = e.dv;
        assign addr_vec[i]  = e.addr;
        assign data_vec[i]  = e.data;
    end

    assign alloc_tag = tail;
    assign mem_valid = any_cmp;
    assign mem_addr  = addr_vec[head];
    assign mem_data  = data_vec[head];

    sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
        .ent_v     (valid_vec),
        .ent_c     (cmp_vec),
        .ent_addr  (addr_vec),
        .ent_data  (data_vec),
        .head      (head),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_result (ld_result),
        .ld_data   (ld_data)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_data,
    input logic             flush,
    input logic [1:0]       ld_result,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] cmp_vec,
    input logic [PW-1:0]    head,
    input logic [CW-1:0]    cmp_cnt,
    input logic [CW-1:0]    fin_cnt
);
    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R3
    mem_src_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> valid_vec[head] && cmp_vec[head]);

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_vec) == int'(cmp_cnt) + int'(fin_cnt));

    // R2
    full_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_vec) == DEPTH) |-> !alloc_ready);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ld_result != 2'd1);

    // R8
    fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
        ld_result == 2'd2 |-> (valid_vec & cmp_vec) != '0);
endmodule

bind store_fwd_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_ready (alloc_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .flush       (flush),
    .ld_result   (ld_result),
    .valid_vec   (valid_vec),
    .cmp_vec     (cmp_vec),
    .head        (head),
    .cmp_cnt     (cmp_cnt),
    .fin_cnt     (fin_cnt)
);

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;
    localparam int DEPTH = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 3;

    logic clk = 0, rst = 1;
    logic alloc_valid = 0, wr_valid = 0, retire = 0, flush = 0, mem_ready = 0, ld_valid = 0;
    logic [AW-1:0] alloc_addr = '0, ld_addr = '0;
    logic [PW-1:0] wr_tag = '0;
    logic [DW-1:0] wr_data = '0;
    logic          alloc_ready, mem_valid;
    logic [PW-1:0] alloc_tag;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data, ld_data;
    logic [1:0]    ld_result;

    always #2 clk = ~clk;

    store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit dv;
        bit c;
        int slot;
    } me_t;
    me_t q[$];
    int head_slot = 0;
    int n_chk = 0, n_fail = 0;
    string phase = "";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", (phase != "") ? phase : req, what, act, exp);
        end
    endtask

    function automatic int n_cmp();
        int n = 0;
        foreach (q[i]) if (q[i].c) n++;
        return n;
    endfunction

    function automatic int last_slot();
        return q[q.size()-1].slot;
    endfunction

    task automatic compare();
        bit er, emv;
        int res, sel;
        er = !flush && q.size() < DEPTH;
        chk(alloc_ready == er, "R2", "alloc_ready", alloc_ready, er);
        if (er) chk(alloc_tag == PW'((head_slot + q.size()) % DEPTH), "R2", "alloc_tag",
                    alloc_tag, (head_slot + q.size()) % DEPTH);
        emv = q.size() > 0 && q[0].c;
        chk(mem_valid == emv, "R3", "mem_valid", mem_valid, emv);
        if (emv) begin
            chk(mem_addr == q[0].a, "R4", "mem_addr", mem_addr, q[0].a);
            chk(mem_data == q[0].d, "R4", "mem_data", mem_data, q[0].d);
        end
        if (ld_valid) begin
            res = 0; sel = -1;
            foreach (q[i]) if (q[i].a == ld_addr) begin
                if (!q[i].c) res = 1;
                else sel = i;
            end
            if (res == 0 && sel >= 0) res = 2;
            chk(ld_result == 2'(res), (res == 0) ? "R6" : (res == 1) ? "R7" : "R8",
                "ld_result", ld_result, res);
            if (res == 2) chk(ld_data == q[sel].d, "R8", "ld_data", ld_data, q[sel].d);
        end
    endtask

    task automatic model_update();
        bit can_a, dr, ret_ok;
        int nc;
        can_a  = !flush && q.size() < DEPTH;
        dr     = q.size() > 0 && q[0].c && mem_ready;
        nc     = n_cmp();
        ret_ok = retire && !flush && nc < q.size() && q[nc].dv;
        if (wr_valid) foreach (q[i]) if (q[i].slot == int'(wr_tag) && !q[i].c) begin
            q[i].dv = 1;
            q[i].d  = wr_data;
        end
        if (ret_ok) q[nc].c = 1;
        if (dr) begin
            void'(q.pop_front());
            head_slot = (head_slot + 1) % DEPTH;
        end
        if (flush) begin
            while (q.size() > 0 && !q[q.size()-1].c) void'(q.pop_back());
        end else if (alloc_valid && can_a) begin
            me_t e;
            e.a = alloc_addr; e.d = '0; e.dv = 0; e.c = 0;
            e.slot = (head_slot + q.size()) % DEPTH;
            q.push_back(e);
        end
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        alloc_valid = 0; wr_valid = 0; retire = 0; flush = 0;
    endtask

    task automatic do_alloc(input logic [AW-1:0] a);
        alloc_valid = 1; alloc_addr = a; step();
    endtask

    task automatic do_write(input int slot, input logic [DW-1:0] d);
        wr_valid = 1; wr_tag = PW'(slot); wr_data = d; step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        phase = "R1"; ld_valid = 1; ld_addr = 16'h5;
        step();
        // R8: two completed stores to one address, youngest forwards
        phase = "R8"; mem_ready = 0;
        do_alloc(16'h5); do_write(last_slot(), 32'hAAAA0001);
        do_alloc(16'h5); do_write(last_slot(), 32'hBBBB0002);
        retire = 1; step(); retire = 1; step();
        step();
        // R5: retire without data is ignored; lookup still stalls
        phase = "R5"; ld_addr = 16'h7;
        do_alloc(16'h7);
        retire = 1; step();
        step();
        phase = "R7"; do_write(last_slot(), 32'h77770007); step();
        phase = "R5"; retire = 1; step(); step();
        // R10: write to a completed slot leaves its data
        phase = "R10"; do_write(last_slot(), 32'hDEAD0000); step();
        ld_addr = 16'h5; step();
        // R9: flush drops finished, completed drain
        phase = "R9"; ld_addr = 16'h9;
        do_alloc(16'h9); do_write(last_slot(), 32'h99990009);
        flush = 1; retire = 1; alloc_valid = 1; alloc_addr = 16'h9; step();
        step();
        mem_ready = 1;
        repeat (4) step();
        // R2: fill to full
        phase = "R2"; mem_ready = 0;
        for (int i = 0; i < DEPTH + 2; i++) do_alloc(AW'(i));
        flush = 1; step(); step();
        // random phase
        phase = "";
        for (int n = 0; n < 4000; n++) begin
            alloc_valid = ($urandom % 2) == 0;
            alloc_addr  = AW'($urandom % 4);
            wr_valid    = ($urandom % 2) == 0;
            s = $urandom % DEPTH;
            foreach (q[i]) if (!q[i].c && !q[i].dv && ($urandom % 2) == 0) s = q[i].slot;
            wr_tag      = PW'(s);
            wr_data     = $urandom;
            retire      = ($urandom % 10) < 3;
            flush       = ($urandom % 50) == 0;
            mem_ready   = ($urandom % 2) == 0;
            ld_valid    = ($urandom % 8) != 0;
            ld_addr     = AW'($urandom % 4);
            step();
        end
        summary();
        $finish;
    end
endmodule